// File: doc/BRIEF.md
# Bi-phase mark clock and data decoder

This block takes a single serial line carrying a bi-phase-mark stream and recovers from it a bit-rate clock and a stream of command bits. It works entirely in the domain of a free-running sampling clock that runs at least eight times faster than the bit rate. In the stream, every bit period begins with a line transition. A bit whose value is one adds a second transition halfway through the period. A stream of all-zero bits is therefore a square wave at half the bit rate.

Before it can decode anything, the block has to be trained on an all-zero stream. During training it measures the spacing between transitions in sampling-clock cycles and builds up a period estimate, changing that estimate by no more than one cycle at a time. Once the estimate is trusted, the block raises its lock flag. From then on it drives a recovered bit clock with a 50% duty cycle that restarts at every leading transition. Transitions in the middle half of a bit are treated as data and never move the clock. Each decoded bit is presented for one whole bit period. If the line goes quiet, the block drops lock and starts training again.

Top module: `bpm_decoder`

## Requirements
- R1: While reset is asserted, `bit_clk`, `data_out` and `locked` are all 0.
- R2: During training, the block averages the spacing between transitions over windows of 16 spacings, rounding to the nearest cycle. `locked` rises only after four windows in a row whose average lies within one cycle of the held period estimate. The estimate starts from the parameter `NOM_PER`, which is 8. With an idle line whose period is `NOM_PER`, lock therefore comes at the end of the fourth window.
- R3: While locked, `bit_clk` repeats every P sampling cycles, where P is the even learned period. It is high for P/2 cycles and low for P/2 cycles, and it rises just after the detected leading transition of each bit.
- R4: While locked, a transition whose distance from the last leading transition falls in the central half of the period (at least P/4 and below 3P/4 cycles) does not restart the bit clock. `bit_clk` keeps exactly the same period and high time whether the bits being sent are ones or zeros.
- R5: Line encoding: every bit starts with a transition, and a bit of value 1 adds a transition P/2 cycles after the start. On each mid-bit transition the block captures the level of its recovered clock just before that transition. The captured value is shown on `data_out` with a latency of one bit: 1 means a mid-bit transition occurred, 0 means none.
- R6: While locked, `data_out` changes only in the cycle in which `bit_clk` rises. Each decoded value is therefore held for a full bit period.
- R7: While locked, if no transition arrives for 2·P sampling cycles, `locked` falls 2·P+3 cycles after the last line transition. Training then restarts, and `bit_clk` and `data_out` go to 0.
- R8: At the end of each training window, the period estimate moves toward the measured average by at most one cycle. After a period change from 8 to 12, relock therefore takes seven windows rather than four, which is at least 96·12 cycles.
- R9: Whenever `locked` is 0, `bit_clk` is 0. From the second unlocked cycle onward, `data_out` is also 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_os | input | 1 | Free-running sampling clock, at least 8x the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| line_in | input | 1 | Raw bi-phase-mark line level, asynchronous to clk_os |
| bit_clk | output | 1 | Recovered bit clock, 50% duty cycle, low when unlocked |
| data_out | output | 1 | Decoded command bit, held for one bit period |
| locked | output | 1 | High while the period estimate is trusted and decoding is active |

## Verification
The bench looks at several corner cases, and each one catches a different kind of bug. It measures how many cycles lock takes, both at the nominal period and after retraining at a longer period. A decoder that locks on a single agreeing window shows up as locking too early. A decoder that jumps its estimate instead of slewing it also locks too early after retraining. The bench sends long runs of ones, alternating patterns and random bits, and times every high phase and every period of `bit_clk`. A blanking window that is too narrow or misplaced would let mid-bit transitions restart the clock, and those timings would come out short. Finally, the bench stops the line and measures how long `locked` survives. A timeout counted from the wrong transition, or with the wrong length, would drop lock at the wrong cycle or never drop it at all.

// File: rtl/bpm_pkg.sv
package bpm_pkg;

  typedef enum logic [0:0] {
    ST_TRAIN = 1'b0,
    ST_LOCK  = 1'b1
  } bpm_state_e;

endpackage

// File: rtl/bpm_edge_det.sv
module bpm_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic edge_o
);

  // sh_q[SYNC_STAGES-1] is the synchronized level; sh_q[SYNC_STAGES] is one cycle older
  logic [SYNC_STAGES:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[SYNC_STAGES-1:0], line_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign edge_o = sh_q[SYNC_STAGES] ^ sh_q[SYNC_STAGES-1];

endmodule

// File: rtl/bpm_trainer.sv
module bpm_trainer
  import bpm_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int AVG_LOG2 = 4,
  parameter int AGREE_N  = 4,
  parameter int NOM_PER  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             edge_i,
  output logic             lock_o,
  output logic [CNT_W-1:0] per_o
);

  localparam int ACC_W  = CNT_W + AVG_LOG2;
  localparam int ACC_W1 = ACC_W + 1;
  localparam int AGR_W  = $clog2(AGREE_N + 1);
  localparam logic [ACC_W1-1:0] RND = ACC_W1'(2 ** (AVG_LOG2 - 1));

  bpm_state_e          st_q, st_d;
  logic [CNT_W-1:0]    sil_q, sil_d;
  logic                armed_q, armed_d;
  logic [AVG_LOG2-1:0] n_q, n_d;
  logic [ACC_W-1:0]    acc_q, acc_d;
  logic [CNT_W-1:0]    per_q, per_d;
  logic [AGR_W-1:0]    agree_q, agree_d;

  logic [CNT_W-1:0]  sil_inc;
  logic              timeout;
  logic [ACC_W-1:0]  acc_sum;
  logic [ACC_W1-1:0] acc_rnd;
  logic [ACC_W1-1:0] avg_w;
  logic [CNT_W-1:0]  avg;
  logic [CNT_W-1:0]  dif;
  logic              near;
  logic [CNT_W-1:0]  per_step;

  // datapath: spacing, rounded window average, slewed period step
  always_comb begin
    sil_inc  = (&sil_q) ? sil_q : sil_q + 1'b1;
    timeout  = {1'b0, sil_inc} >= {per_q, 1'b0};
    acc_sum  = acc_q + ACC_W'(sil_inc);
    acc_rnd  = {1'b0, acc_sum} + RND;
    avg_w    = acc_rnd >> AVG_LOG2;
    avg      = (|avg_w[ACC_W1-1:CNT_W]) ? '1 : avg_w[CNT_W-1:0];
    dif      = (avg >= per_q) ? avg - per_q : per_q - avg;
    near     = dif <= CNT_W'(1);
    if (avg > per_q) begin
      per_step = per_q + 1'b1;
    end else if (avg < per_q) begin
      per_step = per_q - 1'b1;
    end else begin
      per_step = per_q;
    end
  end

  // next state
  always_comb begin
    st_d    = st_q;
    armed_d = armed_q;
    n_d     = n_q;
    acc_d   = acc_q;
    per_d   = per_q;
    agree_d = agree_q;
    sil_d   = edge_i ? '0 : sil_inc;
    unique case (st_q)
      ST_TRAIN: begin
        if (edge_i) begin
          if (!armed_q) begin
            armed_d = 1'b1;
            n_d     = '0;
            acc_d   = '0;
          end else if (&n_q) begin
            n_d   = '0;
            acc_d = '0;
            per_d = per_step;
            if (near) begin
              if (agree_q == AGR_W'(AGREE_N - 1)) begin
                st_d    = ST_LOCK;
                agree_d = '0;
              end else begin
                agree_d = agree_q + 1'b1;
              end
            end else begin
              agree_d = '0;
            end
          end else begin
            n_d   = n_q + 1'b1;
            acc_d = acc_sum;
          end
        end
      end
      ST_LOCK: begin
        if (!edge_i && timeout) begin
          st_d    = ST_TRAIN;
          armed_d = 1'b0;
          agree_d = '0;
          n_d     = '0;
          acc_d   = '0;
        end
      end
      default: st_d = ST_TRAIN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_TRAIN;
      sil_q   <= '0;
      armed_q <= 1'b0;
      n_q     <= '0;
      acc_q   <= '0;
      per_q   <= CNT_W'(NOM_PER);
      agree_q <= '0;
    end else begin
      st_q    <= st_d;
      sil_q   <= sil_d;
      armed_q <= armed_d;
      n_q     <= n_d;
      acc_q   <= acc_d;
      per_q   <= per_d;
      agree_q <= agree_d;
    end
  end

  assign lock_o = (st_q == ST_LOCK);
  assign per_o  = per_q;

  AST_PER_SLEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_q == $past(per_q)) || (per_q == $past(per_q) + 1'b1) || (per_q == $past(per_q) - 1'b1)); // R8
  AST_LOCK_AFTER_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_q == ST_LOCK) |-> $past(edge_i)); // R2
  AST_TIMEOUT_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LOCK && !edge_i && timeout) |=> (st_q == ST_TRAIN)); // R7
  AST_PER_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LOCK && $past(st_q) == ST_LOCK) |-> $stable(per_q)); // R3

endmodule

// File: rtl/bpm_phase.sv
module bpm_phase #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             edge_i,
  input  logic             lock_i,
  input  logic [CNT_W-1:0] per_i,
  output logic             bclk_o,
  output logic             data_o
);

  logic [CNT_W-1:0] ph_q, ph_d;
  logic             clk_q, clk_d;
  logic             flag_q, flag_d;
  logic             data_q, data_d;

  logic [CNT_W-1:0] half, quarter, upper, pos;
  logic             blank, resync, mid;

  // blanking window over the central half of the learned period
  always_comb begin
    half    = per_i >> 1;
    quarter = per_i >> 2;
    upper   = per_i - quarter;
    pos     = (&ph_q) ? ph_q : ph_q + 1'b1;
    blank   = (pos >= quarter) && (pos < upper);
    resync  = edge_i && (!lock_i || !blank);
    mid     = edge_i && lock_i && blank;
  end

  always_comb begin
    ph_d   = resync ? '0 : pos;
    clk_d  = ph_d < half;
    flag_d = flag_q;
    data_d = data_q;
    if (!lock_i) begin
      flag_d = 1'b0;
      data_d = 1'b0;
    end else if (resync) begin
      data_d = flag_q;
      flag_d = 1'b0;
    end else if (mid) begin
      flag_d = flag_q | clk_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= '0;
      clk_q  <= 1'b0;
      flag_q <= 1'b0;
      data_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      clk_q  <= clk_d;
      flag_q <= flag_d;
      data_q <= data_d;
    end
  end

  assign bclk_o = clk_q & lock_i;
  assign data_o = data_q;

  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(data_q) && $past(lock_i)) |-> (ph_q == '0)); // R6
  AST_BLANK_NO_RESYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i && edge_i && blank) |=> (ph_q == $past(ph_q) + 1'b1)); // R4

endmodule

// File: rtl/bpm_decoder.sv
module bpm_decoder #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 8,
  parameter int AVG_LOG2    = 4,
  parameter int AGREE_N     = 4,
  parameter int NOM_PER     = 8
) (
  input  logic clk_os,
  input  logic rst_n,
  input  logic line_in,
  output logic bit_clk,
  output logic data_out,
  output logic locked
);

  logic [1:0]       rs_q;
  logic             rst_int_n;
  logic             edge_w;
  logic             lock_w;
  logic [CNT_W-1:0] per_w;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk_os or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_int_n = rs_q[1];

  bpm_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_os),
    .rst_ni (rst_int_n),
    .line_i (line_in),
    .edge_o (edge_w)
  );

  bpm_trainer #(
    .CNT_W    (CNT_W),
    .AVG_LOG2 (AVG_LOG2),
    .AGREE_N  (AGREE_N),
    .NOM_PER  (NOM_PER)
  ) u_train (
    .clk_i  (clk_os),
    .rst_ni (rst_int_n),
    .edge_i (edge_w),
    .lock_o (lock_w),
    .per_o  (per_w)
  );

  bpm_phase #(.CNT_W(CNT_W)) u_phase (
    .clk_i  (clk_os),
    .rst_ni (rst_int_n),
    .edge_i (edge_w),
    .lock_i (lock_w),
    .per_i  (per_w),
    .bclk_o (bit_clk),
    .data_o (data_out)
  );

  assign locked = lock_w;

  AST_CLK_GATED: assert property (@(posedge clk_os) disable iff (!rst_int_n)
    !locked |-> !bit_clk); // R9
  AST_DATA_GATED: assert property (@(posedge clk_os) disable iff (!rst_int_n)
    (!locked && !$past(locked)) |-> !data_out); // R9

endmodule

// File: tb/sim_bpm_decoder.sv
module sim_bpm_decoder;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic line;
  logic bit_clk, data_out, locked;

  bpm_decoder u0 (
    .clk_os   (clk),
    .rst_n    (rst_n),
    .line_in  (line),
    .bit_clk  (bit_clk),
    .data_out (data_out),
    .locked   (locked)
  );

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int last_tog = 0;
  int lock_rise = -1;
  int lock_fall = -1;
  logic lk_prev = 1'b0;

  bit    mon_en = 1'b0;
  string mon_req = "R3";
  int    p_exp = 8;
  logic  pb = 1'b0;
  logic  pd = 1'b0;
  int    hi_run = 0;
  int    last_rise = -1;
  int    r6_bad = 0;
  int    r9_bad = 0;
  int    obs[$];
  int    sent[$];

  function automatic int exp_lock(int p, int windows);
    return windows * 16 * p + 3;
  endfunction

  function automatic int exp_drop(int p);
    return 2 * p + 3;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(logic lv);
    @(negedge clk);
    cyc++;
    if (locked && !lk_prev) lock_rise = cyc;
    if (!locked && lk_prev) lock_fall = cyc;
    if (!locked && lk_prev == 1'b0 && (bit_clk || data_out)) r9_bad++;
    if (mon_en) begin
      if (bit_clk && !pb) begin
        if (last_rise >= 0)
          check(cyc - last_rise == p_exp, mon_req, "bit clock period", cyc - last_rise, p_exp);
        last_rise = cyc;
        obs.push_back(int'(data_out));
      end
      if (!bit_clk && pb)
        check(hi_run == p_exp / 2, mon_req, "bit clock high time", hi_run, p_exp / 2);
      if (locked && lk_prev && data_out != pd && !(bit_clk && !pb)) r6_bad++;
    end
    hi_run = bit_clk ? hi_run + 1 : 0;
    pb = bit_clk;
    pd = data_out;
    lk_prev = locked;
    if (lv != line) last_tog = cyc;
    line = lv;
  endtask

  task automatic send_bit(bit d, int p);
    logic lv;
    lv = line;
    for (int c = 0; c < p; c++) begin
      if (c == 0) lv = ~lv;
      if (d && c == p / 2) lv = ~lv;
      step(lv);
    end
  endtask

  task automatic train(int p, output int t_lock);
    int t0;
    t0 = cyc + 1;
    lock_rise = -1;
    for (int b = 0; b < 200 && lock_rise < 0; b++) send_bit(1'b0, p);
    t_lock = (lock_rise < 0) ? -1 : lock_rise - t0;
  endtask

  task automatic data_phase(int p, string req);
    int best_d, best_m, mism;
    for (int b = 0; b < 4; b++) send_bit(1'b0, p);
    sent.delete();
    obs.delete();
    p_exp = p;
    mon_req = req;
    last_rise = -1;
    r6_bad = 0;
    mon_en = 1'b1;
    for (int i = 0; i < 6; i++) sent.push_back(1);
    for (int i = 0; i < 6; i++) sent.push_back(i % 2);
    for (int i = 0; i < 36; i++) sent.push_back(int'($urandom() & 1));
    foreach (sent[i]) send_bit(sent[i][0], p);
    for (int b = 0; b < 3; b++) send_bit(1'b0, p);
    mon_en = 1'b0;
    best_d = 0;
    best_m = -1;
    for (int d = 0; d < 4; d++) begin
      int m;
      m = 0;
      for (int i = 0; i < sent.size(); i++)
        if (i + d < obs.size() && obs[i + d] == sent[i]) m++;
      if (m > best_m) begin best_m = m; best_d = d; end
    end
    mism = sent.size() - best_m;
    check(mism == 0, "R5", "decoded bit mismatches", mism, 0);
    check(best_d == 1, "R5", "decode latency in bits", best_d, 1);
    check(r6_bad == 0, "R6", "data changes away from clock rise", r6_bad, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R2 watchdog: actual %0d expected %0d", 200000, 0);
    summary();
    $finish;
  end

  initial begin
    int t_lock, t_drop, seed_dummy;
    seed_dummy = $urandom(32'h0b1f_5eed);
    rst_n = 1'b0;
    line = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(!bit_clk && !data_out && !locked, "R1", "outputs in reset",
            int'({bit_clk, data_out, locked}), 0);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) step(1'b0);
    check(!locked, "R1", "locked after reset release", int'(locked), 0);

    // nominal period training
    r9_bad = 0;
    train(8, t_lock);
    check(t_lock >= exp_lock(8, 4) - 5 && t_lock <= exp_lock(8, 4) + 7, "R2",
          "lock time at nominal period", t_lock, exp_lock(8, 4));
    check(r9_bad == 0, "R9", "outputs active while unlocked", r9_bad, 0);

    data_phase(8, "R4");

    // silence: timeout drops lock
    send_bit(1'b0, 8);
    send_bit(1'b0, 8);
    lock_fall = -1;
    for (int i = 0; i < 40 && lock_fall < 0; i++) step(line);
    t_drop = (lock_fall < 0) ? -1 : lock_fall - last_tog;
    check(t_drop >= exp_drop(8) - 2 && t_drop <= exp_drop(8) + 3, "R7",
          "lock loss delay", t_drop, exp_drop(8));
    step(line);
    check(!bit_clk && !data_out, "R7", "outputs after lock loss",
          int'({bit_clk, data_out}), 0);

    // retrain at a longer period: estimate must slew
    r9_bad = 0;
    train(12, t_lock);
    check(t_lock >= 96 * 12, "R8", "relock not earlier than slew allows", t_lock, exp_lock(12, 7));
    check(t_lock <= exp_lock(12, 7) + 7, "R8", "relock time upper bound", t_lock, exp_lock(12, 7));
    check(r9_bad == 0, "R9", "outputs active while retraining", r9_bad, 0);

    // idle-locked clock shape at new period
    p_exp = 12;
    mon_req = "R3";
    last_rise = -1;
    mon_en = 1'b1;
    for (int b = 0; b < 6; b++) send_bit(1'b0, 12);
    mon_en = 1'b0;

    data_phase(12, "R4");

    summary();
    $finish;
  end

endmodule